// File: doc/BRIEF.md
# FIFO-Gated SPI Master

This block is a serial peripheral master that sits between a transmit FIFO and a receive FIFO. It converts bytes to and from the SCK/MOSI/MISO wires. Two enable inputs pick the kind of transaction:

- **Transmit-only** sends every queued byte and stores nothing.
- **Receive-only** clocks in a programmed number of bytes while MOSI rests high.
- **Full duplex** exchanges one byte for one byte.

Chip selects for individual peripherals are driven by external logic. The FIFOs are ordinary synchronous FIFOs. The transmit FIFO presents its head word on `tx_data` and advances on `tx_pop`. The receive FIFO stores `rx_wdata` on `rx_push`.

The serial clock is not a fixed-length burst. Before each byte the controller checks whether the FIFOs that the current mode uses can supply a byte and accept one. If they cannot, SCK stays parked at its idle level on the byte boundary. The next byte starts as soon as the FIFO condition clears.

SCK polarity, SCK phase and bit order are configuration inputs. The SCK half period is a programmable number of system clocks.

Top module: `spi_fifo_master`

## Requirements
- R1: Mode comes from `{tx_en, rx_en}`:
  - 2'b10 is transmit-only.
  - 2'b01 is receive-only.
  - 2'b11 is full duplex.
  - 2'b00 starts no byte, pops nothing and leaves SCK idle.
- R2: In transmit-only mode, every byte in the transmit FIFO is sent in FIFO order, and `rx_push` never asserts.
- R3: Whenever no byte is in flight, `sck` equals `cpol`. In transmit-only mode an empty transmit FIFO parks SCK at the byte boundary, and a newly written byte restarts it.
- R4: In receive-only mode, a `start` pulse issued while idle loads `xfer_len`. Exactly that many bytes are then pushed, in the order the slave sent them, and `tx_pop` never asserts.
- R5: In receive-only mode, a byte is started only when `rx_full` is low. While the FIFO stays full, SCK rests idle and `busy` stays high. The stream resumes once space appears.
- R6: While a receive-only byte is in flight, `mosi` is 1.
- R7: In full duplex, a byte starts only if `tx_empty` is low and `rx_full` is low. Each byte pops one word and pushes the byte received alongside it. Otherwise SCK pauses.
- R8: For each phase setting:
  - With `cpha`=0, MISO is sampled on the 1st, 3rd, ... 15th SCK edge of a byte and MOSI changes on the others.
  - With `cpha`=1, MISO is sampled on the even-numbered edges and MOSI changes on the odd-numbered ones.
- R9: `lsb_first`=0 sends and receives bit 7 first. `lsb_first`=1 sends and receives bit 0 first.
- R10: Inside a byte, consecutive SCK edges are `clk_div`+1 system clocks apart, and a byte has 16 edges.
- R11: In receive-only mode:
  - `busy` is high from the cycle after `start` until the last byte completes.
  - `done` pulses for one cycle with that last push.
  - `busy` is low on the cycle after `done`.
- R12: `tx_pop` never asserts while `tx_empty` is high, and `rx_push` never asserts while `rx_full` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit path enable |
| rx_en | input | 1 | Receive path enable |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | SCK phase select |
| lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| clk_div | input | DIV_W (8) | SCK half period minus one, in system clocks |
| xfer_len | input | LEN_W (10) | Receive-only byte count |
| start | input | 1 | Begins a receive-only transfer |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| tx_data | input | 8 | Transmit FIFO head word |
| tx_pop | output | 1 | Transmit FIFO read strobe |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_push | output | 1 | Receive FIFO write strobe |
| rx_wdata | output | 8 | Received byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Receive-only count reached zero |

## Verification
The hardest situation to reach is a pause with a full receive FIFO in the middle of a counted receive-only transfer. Part of the count must already be consumed, `busy` must still be high, and SCK must be parked. The bench gets there by giving its FIFO model a capacity smaller than the programmed length. It then holds the FIFO full across hundreds of cycles before lifting the limit. The same capacity trick stalls full duplex with transmit data still queued. A behavioural slave in the bench counts SCK edges to check every polarity, phase and bit-order combination at two divider settings.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  typedef enum logic [1:0] {
    XM_OFF    = 2'b00,
    XM_RX     = 2'b01,
    XM_TX     = 2'b10,
    XM_DUPLEX = 2'b11
  } xfer_mode_e;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned EDGES     = 2 * BYTE_W;
  localparam int unsigned EDGE_W    = $clog2(EDGES);
  localparam logic [7:0]  IDLE_BYTE = 8'hFF;

  function automatic xfer_mode_e decode_mode(input logic tx_on, input logic rx_on);
    return xfer_mode_e'({tx_on, rx_on});
  endfunction

  function automatic logic out_bit(input logic [7:0] b, input logic lsb);
    return lsb ? b[0] : b[7];
  endfunction

  function automatic logic [7:0] advance(input logic [7:0] b, input logic lsb);
    return lsb ? {1'b1, b[7:1]} : {b[6:0], 1'b1};
  endfunction

  function automatic logic [7:0] absorb(input logic [7:0] b, input logic d, input logic lsb);
    return lsb ? {d, b[7:1]} : {b[6:0], d};
  endfunction

  // Edge index e counts SCK edges within a byte from 0 (leading) to 15.
  function automatic logic is_sample_edge(input logic [EDGE_W-1:0] e, input logic ph);
    return ph ? e[0] : ~e[0];
  endfunction

  function automatic logic is_drive_edge(input logic [EDGE_W-1:0] e, input logic ph);
    if (ph) return (~e[0]) && (e != '0);
    return e[0] && (e != EDGE_W'(EDGES - 1));
  endfunction

endpackage

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R10: a run always begins from a fresh count
  a_r10_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpha,
  input  logic       lsb_first,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       tick,
  input  logic       miso,
  output logic       phase,
  output logic       mosi,
  output logic       active,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic [EDGE_W-1:0] edge_cnt;
  logic [7:0]        tsr;
  logic [7:0]        rsr;
  logic              samp_now;
  logic              drive_now;
  logic [7:0]        rsr_next;

  assign samp_now  = active && tick && is_sample_edge(edge_cnt, cpha);
  assign drive_now = active && tick && is_drive_edge(edge_cnt, cpha);
  assign rsr_next  = samp_now ? absorb(rsr, miso, lsb_first) : rsr;
  assign byte_done = active && tick && (edge_cnt == LAST_EDGE);
  assign rx_byte   = rsr_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      edge_cnt <= '0;
      phase    <= 1'b0;
      mosi     <= 1'b1;
      tsr      <= IDLE_BYTE;
      rsr      <= '0;
    end else if (load && !active) begin
      active   <= 1'b1;
      edge_cnt <= '0;
      phase    <= 1'b0;
      mosi     <= out_bit(load_byte, lsb_first);
      tsr      <= advance(load_byte, lsb_first);
    end else if (active && tick) begin
      phase    <= ~phase;
      edge_cnt <= edge_cnt + 1'b1;
      rsr      <= rsr_next;
      if (drive_now) begin
        mosi <= out_bit(tsr, lsb_first);
        tsr  <= advance(tsr, lsb_first);
      end
      if (edge_cnt == LAST_EDGE) active <= 1'b0;
    end
  end

  // R8: a new byte is only loaded at a byte boundary
  a_r8_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active);
  // R8: MOSI never moves on a sampling edge
  a_r8_mosi_steady_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    samp_now |=> $stable(mosi));
  // R10: the phase returns to idle once a byte ends
  a_r10_byte_closes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !phase);

endmodule

// File: rtl/spi_flow_ctrl.sv
module spi_flow_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_mode_e       mode,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic             eng_active,
  input  logic             byte_done,
  output logic             go,
  output logic             tx_pop,
  output logic             rx_push,
  output logic             busy,
  output logic             done
);
  logic [LEN_W-1:0] remaining;
  logic             count_live;
  logic             uses_tx;
  logic             uses_rx;
  logic             may_go;

  assign count_live = (remaining != '0);
  assign uses_tx    = (mode == XM_TX) || (mode == XM_DUPLEX);
  assign uses_rx    = (mode == XM_RX) || (mode == XM_DUPLEX);

  always_comb begin
    case (mode)
      XM_TX:     may_go = !tx_empty;
      XM_RX:     may_go = count_live && !rx_full;
      XM_DUPLEX: may_go = !tx_empty && !rx_full;
      default:   may_go = 1'b0;
    endcase
  end

  assign go      = may_go && !eng_active;
  assign tx_pop  = go && uses_tx;
  assign rx_push = byte_done && uses_rx;
  assign done    = byte_done && (mode == XM_RX) && (remaining == LEN_W'(1));
  assign busy    = eng_active || count_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
    end else if (mode == XM_RX) begin
      if (start && !count_live && !eng_active) remaining <= xfer_len;
      else if (byte_done && count_live)        remaining <= remaining - 1'b1;
    end
  end

  // R12: FIFO flags are honoured
  a_r12_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);
  a_r12_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
  // R2: transmit-only never writes the receive FIFO
  a_r2_tx_only_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XM_TX) |-> !rx_push);
  // R4: receive-only never reads the transmit FIFO
  a_r4_rx_only_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XM_RX) |-> !tx_pop);
  // R1: no enables, no traffic
  a_r1_off_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XM_OFF) |-> !go);
  // R11: busy drops right after the final receive-only byte
  a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == XM_RX) |=> !busy);

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             start,
  input  logic             tx_empty,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [7:0]       rx_wdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             done
);
  xfer_mode_e mode;
  logic       go;
  logic       tick;
  logic       eng_active;
  logic       byte_done;
  logic       phase;
  logic [7:0] load_byte;

  assign mode      = decode_mode(tx_en, rx_en);
  assign load_byte = (mode == XM_RX) ? IDLE_BYTE : tx_data;
  assign sck       = phase ^ cpol;

  spi_sck_divider #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (eng_active),
    .div  (clk_div),
    .tick (tick)
  );

  spi_flow_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .start     (start),
    .xfer_len  (xfer_len),
    .tx_empty  (tx_empty),
    .rx_full   (rx_full),
    .eng_active(eng_active),
    .byte_done (byte_done),
    .go        (go),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .busy      (busy),
    .done      (done)
  );

  spi_byte_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpha     (cpha),
    .lsb_first(lsb_first),
    .load     (go),
    .load_byte(load_byte),
    .tick     (tick),
    .miso     (miso),
    .phase    (phase),
    .mosi     (mosi),
    .active   (eng_active),
    .byte_done(byte_done),
    .rx_byte  (rx_wdata)
  );

  // R3: SCK rests at its idle level between bytes
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_active |-> (sck == cpol));
  // R10: SCK only moves on a divider tick
  a_r10_sck_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_active && !tick) |=> ($stable(sck) || !$stable(cpol)));
  // R6: receive-only keeps MOSI high while shifting
  a_r6_mosi_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XM_RX && eng_active) |-> mosi);

endmodule

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0, cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
  logic [7:0] clk_div = 8'd1;
  logic [9:0] xfer_len = '0;
  logic start = 1'b0;
  logic tx_empty, rx_full, tx_pop, rx_push, sck, mosi, miso, busy, done;
  logic [7:0] tx_data, rx_wdata;

  int total = 0, bad = 0;
  logic [7:0] txq [0:255];
  logic [7:0] rxq [0:255];
  logic [7:0] srx [0:255];
  int tx_wr = 0, tx_rd = 0, rx_wr = 0, rx_rd = 0, rx_cap = 8, done_cnt = 0;
  int stk = 0, srk = 0, sbit = 0, gap = 0, gap_min = 9999, gap_max = 0;
  logic [3:0] ec = '0;
  logic [7:0] sas = '0;
  logic sck_d = 1'b0;
  int tcnt = 0;

  always #5 clk = ~clk;

  assign tx_empty = (tx_wr == tx_rd);
  assign tx_data  = txq[tx_rd % 256];
  assign rx_full  = (rx_wr - rx_rd) >= rx_cap;

  function automatic logic [7:0] sbyte(input int k);
    return 8'((k * 53 + 19) ^ (k >> 2));
  endfunction
  function automatic logic [7:0] tbyte(input int k);
    return 8'(k * 71 + 3);
  endfunction
  function automatic logic slave_bit(input int k, input int j, input logic l);
    logic [7:0] b;
    b = sbyte(k);
    return l ? b[j] : b[7 - j];
  endfunction

  assign miso = slave_bit(stk, sbit, lsb);

  spi_fifo_master dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .cpol(cpol),
    .cpha(cpha), .lsb_first(lsb), .clk_div(clk_div), .xfer_len(xfer_len),
    .start(start), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_wdata(rx_wdata), .sck(sck),
    .mosi(mosi), .miso(miso), .busy(busy), .done(done)
  );

  // FIFO models
  always @(posedge clk) begin
    if (tx_pop) tx_rd <= tx_rd + 1;
    if (rx_push) begin
      rxq[rx_wr % 256] <= rx_wdata;
      rx_wr <= rx_wr + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  // Behavioural slave: counts SCK edges per byte
  always @(posedge clk) begin
    logic [7:0] av;
    if (rst_n && ((sck ^ cpol) != sck_d)) begin
      sck_d <= sck ^ cpol;
      if (ec != 4'd0) begin
        if (gap < gap_min) gap_min <= gap;
        if (gap > gap_max) gap_max <= gap;
      end
      gap <= 1;
      av = sas;
      if (cpha ? ec[0] : !ec[0]) av = lsb ? {mosi, sas[7:1]} : {sas[6:0], mosi};
      sas <= av;
      if (cpha) begin
        if (!ec[0]) sbit <= int'(ec) / 2;
        else if (ec == 4'd15) sbit <= 0;
      end else if (ec[0]) begin
        sbit <= (ec == 4'd15) ? 0 : (int'(ec) + 1) / 2;
      end
      if (ec == 4'd15) begin
        srx[srk % 256] <= av;
        srk <= srk + 1;
        stk <= stk + 1;
      end
      ec <= ec + 4'd1;
    end else begin
      gap <= gap + 1;
    end
  end

  task automatic check(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_tx(input int n);
    for (int i = 0; i < n; i++) begin
      txq[tx_wr % 256] = tbyte(tcnt);
      tcnt++;
      tx_wr++;
    end
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 20000 && quiet < 8; i++) begin
      @(negedge clk);
      if (!busy && (!tx_en || tx_empty || !rx_en && !tx_en)) quiet++;
      else quiet = 0;
      if (tx_en && rx_full && !busy) quiet++;
    end
  endtask

  task automatic set_cfg(input logic t, input logic r, input int c);
    @(negedge clk);
    tx_en = t; rx_en = r;
    cpol = c[0]; cpha = c[1]; lsb = c[2];
  endtask

  task automatic rx_start(input int n);
    @(negedge clk);
    xfer_len = 10'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    int k0, r0, t0, d0;
    repeat (3) @(negedge clk);
    // reset state
    check("R3 reset sck", sck == 1'b0, sck, 0);
    check("R11 reset busy", busy == 1'b0, busy, 0);
    check("R12 reset strobes", !tx_pop && !rx_push && !done, tx_pop, 0);
    rst_n = 1'b1;

    // R1: no enables -> nothing happens
    push_tx(2);
    t0 = tx_rd; k0 = srk;
    repeat (200) @(negedge clk);
    check("R1 off no pop", tx_rd == t0, tx_rd, t0);
    check("R1 off no edge", srk == k0 && sck == cpol, srk, k0);

    for (int dv = 1; dv <= 3; dv += 2) begin
      clk_div = 8'(dv);
      for (int c = 0; c < 8; c++) begin
        // transmit-only: also drains the leftover bytes
        set_cfg(1'b1, 1'b0, c);
        push_tx(2);
        k0 = srk; r0 = rx_wr; t0 = tx_rd;
        gap_min = 9999; gap_max = 0;
        wait_idle();
        check("R2 tx-only count", srk - k0 == tx_wr - t0, srk - k0, tx_wr - t0);
        for (int i = 0; i < tx_wr - t0; i++)
          check("R2 R9 tx byte", srx[(k0 + i) % 256] == txq[(t0 + i) % 256],
                srx[(k0 + i) % 256], txq[(t0 + i) % 256]);
        check("R2 tx-only no push", rx_wr == r0, rx_wr, r0);
        check("R10 half period", gap_min == dv + 1 && gap_max == dv + 1, gap_min, dv + 1);
        check("R3 idle level", sck == cpol, sck, cpol);

        // full duplex
        set_cfg(1'b1, 1'b1, c);
        rx_rd = rx_wr;
        push_tx(3);
        k0 = srk; r0 = rx_wr; t0 = tx_rd;
        wait_idle();
        check("R7 duplex count", rx_wr - r0 == 3, rx_wr - r0, 3);
        for (int i = 0; i < 3; i++) begin
          check("R7 R8 R9 duplex out", srx[(k0 + i) % 256] == txq[(t0 + i) % 256],
                srx[(k0 + i) % 256], txq[(t0 + i) % 256]);
          check("R7 R8 R9 duplex in", rxq[(r0 + i) % 256] == sbyte(k0 + i),
                rxq[(r0 + i) % 256], sbyte(k0 + i));
        end

        // receive-only
        set_cfg(1'b0, 1'b1, c);
        rx_rd = rx_wr;
        k0 = srk; r0 = rx_wr; d0 = done_cnt; t0 = tx_rd;
        push_tx(1);
        rx_start(3);
        check("R11 busy after start", busy == 1'b1, busy, 1);
        wait_idle();
        check("R4 rx-only count", rx_wr - r0 == 3, rx_wr - r0, 3);
        for (int i = 0; i < 3; i++) begin
          check("R4 R8 R9 rx byte", rxq[(r0 + i) % 256] == sbyte(k0 + i),
                rxq[(r0 + i) % 256], sbyte(k0 + i));
          check("R6 mosi high", srx[(k0 + i) % 256] == 8'hFF, srx[(k0 + i) % 256], 255);
        end
        check("R4 rx-only no pop", tx_rd == t0, tx_rd, t0);
        check("R11 one done", done_cnt - d0 == 1, done_cnt - d0, 1);
        check("R11 busy low", busy == 1'b0, busy, 0);
      end
    end

    // R3: transmit-only stall and restart
    clk_div = 8'd1;
    set_cfg(1'b1, 1'b0, 1);
    wait_idle();
    k0 = srk;
    repeat (60) @(negedge clk);
    check("R3 parked", sck == cpol && srk == k0 && !busy, srk, k0);
    t0 = tx_rd;
    push_tx(1);
    wait_idle();
    check("R3 restart", srk == k0 + 1 && srx[k0 % 256] == txq[t0 % 256], srk, k0 + 1);

    // R5: receive-only held by a full FIFO
    set_cfg(1'b0, 1'b1, 2);
    rx_rd = rx_wr; rx_cap = 2;
    k0 = srk; r0 = rx_wr; d0 = done_cnt;
    rx_start(4);
    repeat (400) @(negedge clk);
    check("R5 stalled count", rx_wr - r0 == 2, rx_wr - r0, 2);
    check("R5 busy while stalled", busy == 1'b1, busy, 1);
    check("R5 sck parked", sck == cpol, sck, cpol);
    check("R11 no early done", done_cnt == d0, done_cnt, d0);
    rx_cap = 8;
    wait_idle();
    check("R5 resumed count", rx_wr - r0 == 4, rx_wr - r0, 4);
    check("R5 resumed data", rxq[(r0 + 3) % 256] == sbyte(k0 + 3),
          rxq[(r0 + 3) % 256], sbyte(k0 + 3));
    check("R11 done after resume", done_cnt - d0 == 1, done_cnt - d0, 1);

    // R7: duplex held by a full FIFO with transmit data queued
    set_cfg(1'b1, 1'b1, 5);
    rx_rd = rx_wr; rx_cap = 1;
    r0 = rx_wr; k0 = srk; t0 = tx_rd;
    push_tx(3);
    repeat (300) @(negedge clk);
    check("R7 stall push", rx_wr - r0 == 1, rx_wr - r0, 1);
    check("R7 stall keeps tx", tx_wr - tx_rd == 2, tx_wr - tx_rd, 2);
    check("R7 stall sck", sck == cpol && !busy, sck, cpol);
    rx_cap = 8;
    wait_idle();
    check("R7 resume count", rx_wr - r0 == 3, rx_wr - r0, 3);
    check("R7 resume data", srx[(k0 + 2) % 256] == txq[(t0 + 2) % 256],
          srx[(k0 + 2) % 256], txq[(t0 + 2) % 256]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule